// File: doc/BRIEF.md
# LCD Panel Data Bus Formatter

This block turns a stream of pixels for one scan line into the words that are driven onto a 24-line LCD data bus. A 3-bit mode input selects the panel wiring. Five modes are supported: passive-matrix (STN) single scan on 4 or 8 lines, STN dual scan on 8 or 16 lines, and active-matrix (TFT) single scan on all 24 lines. In the STN modes, each pixel supplies either one bit (mono) or three bits (colour, red first, then green, then blue). These bits are packed back to back into bus words, so a pixel's bits may be split across two words. In the TFT modes, each pixel becomes one bus word, and the three colour bytes are reordered onto the bus.

Pixels arrive on a ready/valid stream for the upper panel half. A second, 3-bit stream for the lower half is used only in dual scan. The output is the registered bus word together with a one-cycle shift strobe. The pixel source marks the last pixel of a line. The block then sends out any partly filled word, padded with zeros, so that every line starts on a fresh word.

Top module: `lcd_bus_formatter`

## Requirements
- R1: After reset `lcd_data` is all zeros and `lcd_strobe` is low.
- R2: Mode 0 (STN, 4 lines): words use lines 3:0, the earliest bit of a word is on line 3, and lines 23:4 stay 0.
- R3: Mode 1 (STN, 8 lines): words use lines 7:0, the earliest bit is on line 7, and lines 23:8 stay 0.
- R4: Mode 2 (dual scan, 8 lines): the upper-half word is on lines 3:0 and the lower-half word is on lines 7:4, each with its earliest bit on the highest line; lines 23:8 stay 0.
- R5: Mode 3 (dual scan, 16 lines): the upper-half word is on lines 7:0 and the lower-half word is on lines 15:8; lines 23:16 stay 0.
- R6: With `color` low an STN pixel contributes one bit (`up_pix[0]` and `lo_pix[0]`). With `color` high it contributes three bits in the order `up_pix[23]`, `up_pix[15]`, `up_pix[7]` (lower half: `lo_pix[2]`, `lo_pix[1]`, `lo_pix[0]`). Bits left over after a full word carry into the next word.
- R7: When the pixel marked with `up_last` leaves a partial word, that word is sent padded with zeros on its low lines. If the same pixel also completes a word, the padded word follows one cycle later, and `up_ready` is low for that cycle.
- R8: In dual scan a pixel pair is accepted only in a cycle where both `up_valid` and `lo_valid` are high. `up_ready` is low whenever `lo_valid` is low.
- R9: Mode 4 (TFT): a pixel `{r,g,b}` (r in bits 23:16) is driven as red on lines 7:0, green on 15:8 and blue on 23:16. Each component keeps only its `tft_depth` most significant bits and the rest are 0. A depth of 0 or above 8 means 8.
- R10: Modes 5 to 7 accept nothing and issue no strobe. Outside dual scan `lo_ready` stays low and `lo_pix` has no effect.
- R11: Exactly one strobe is issued per bus word. In TFT mode the strobe is high in the cycle right after the clock edge that accepts the pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 3 | Panel wiring select (0 to 4 valid) |
| color | input | 1 | STN colour (3 bits per pixel) when high, mono when low |
| tft_depth | input | 4 | Significant bits per colour component in TFT mode |
| up_valid | input | 1 | Upper-half pixel valid |
| up_ready | output | 1 | Upper-half pixel accepted when high with `up_valid` |
| up_pix | input | 24 | Upper-half pixel `{r,g,b}` |
| up_last | input | 1 | Marks the last pixel of the line |
| lo_valid | input | 1 | Lower-half pixel valid (dual scan) |
| lo_ready | output | 1 | Lower-half pixel accepted |
| lo_pix | input | 3 | Lower-half STN pixel bits `{r,g,b}` |
| lcd_data | output | 24 | Registered bus word |
| lcd_strobe | output | 1 | One-cycle pulse when a new bus word is on `lcd_data` |

## Verification
The assertions assume that `mode`, `color` and `tft_depth` change only between lines, after the last word of a line has been strobed, and that in dual scan the `up_last` marker goes with the matching lower-half pixel. The bench follows these rules: it changes configuration only while both valid inputs are low and the strobe count for the previous line is complete. It holds each pixel, including its last flag, until the pixel is accepted, and it feeds both halves from the same pixel index. The valid inputs are gated by arithmetic patterns, so that stalls, one-sided valids and straddling colour pixels all occur within these rules.

// File: rtl/lcdf_pkg.sv
package lcdf_pkg;
  localparam int unsigned COMP_W = 8;

  typedef enum logic [2:0] {
    MODE_STN4   = 3'd0,
    MODE_STN8   = 3'd1,
    MODE_DUAL8  = 3'd2,
    MODE_DUAL16 = 3'd3,
    MODE_TFT    = 3'd4
  } lcdf_mode_e;
endpackage

// File: rtl/lcdf_rst_sync.sv
module lcdf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/lcdf_lane_packer.sv
module lcdf_lane_packer #(
  parameter int unsigned LANE_MAX = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic                flush,
  input  logic                last,
  input  logic                rgb,
  input  logic                wide,
  input  logic [2:0]          bits,
  output logic                emit,
  output logic                need_flush,
  output logic [LANE_MAX-1:0] word
);
  localparam int unsigned ACC_W = LANE_MAX + 3;
  localparam int unsigned CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc_q, acc_d, app, word_full;
  logic [CNT_W-1:0] cnt_q, cnt_d, k, w, n, keep;
  logic [LANE_MAX-1:0] lane_mask;
  logic en;

  always_comb begin
    k    = rgb  ? CNT_W'(3) : CNT_W'(1);
    w    = wide ? CNT_W'(LANE_MAX) : CNT_W'(LANE_MAX / 2);
    n    = cnt_q + k;
    app  = rgb ? ((acc_q << 3) | ACC_W'(bits)) : ((acc_q << 1) | ACC_W'(bits[0]));
    lane_mask  = wide ? {LANE_MAX{1'b1}} : LANE_MAX'({(LANE_MAX/2){1'b1}});
    keep       = '0;
    acc_d      = acc_q;
    cnt_d      = cnt_q;
    emit       = 1'b0;
    need_flush = 1'b0;
    word_full  = '0;
    if (flush) begin
      word_full = acc_q << (w - cnt_q);
      acc_d     = '0;
      cnt_d     = '0;
      emit      = 1'b1;
    end else if (push) begin
      if (n >= w) begin
        keep       = n - w;
        word_full  = app >> keep;
        acc_d      = app & ~({ACC_W{1'b1}} << keep);
        cnt_d      = keep;
        emit       = 1'b1;
        need_flush = last && (keep != '0);
      end else if (last) begin
        word_full = app << (w - n);
        acc_d     = '0;
        cnt_d     = '0;
        emit      = 1'b1;
      end else begin
        acc_d = app;
        cnt_d = n;
      end
    end
    word = word_full[LANE_MAX-1:0] & lane_mask;
  end

  assign en = push | flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R6: the held bit count never reaches a full word
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < w);

  // R7: a flush cycle always has held bits to send
  p_flush_has_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (cnt_q != '0));
endmodule

// File: rtl/lcdf_tft_map.sv
module lcdf_tft_map #(
  parameter int unsigned COMP_W  = 8,
  parameter int unsigned DEPTH_W = 4
) (
  input  logic [3*COMP_W-1:0] pix,
  input  logic [DEPTH_W-1:0]  depth,
  output logic [3*COMP_W-1:0] bus
);
  logic [DEPTH_W-1:0] eff;
  logic [COMP_W-1:0]  keep_mask;

  always_comb begin
    eff = ((depth == '0) || (depth > DEPTH_W'(COMP_W))) ? DEPTH_W'(COMP_W) : depth;
    keep_mask = ~({COMP_W{1'b1}} >> eff);
  end

  // bus component c (0 = red) takes pixel component 2-c (pixel is {r,g,b})
  for (genvar c = 0; c < 3; c++) begin : g_comp
    assign bus[c*COMP_W +: COMP_W] = pix[(2-c)*COMP_W +: COMP_W] & keep_mask;
  end
endmodule

// File: rtl/lcd_bus_formatter.sv
module lcd_bus_formatter
  import lcdf_pkg::*;
#(
  parameter int unsigned CW = lcdf_pkg::COMP_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                mode,
  input  logic                      color,
  input  logic [$clog2(CW+1)-1:0]   tft_depth,
  input  logic                      up_valid,
  output logic                      up_ready,
  input  logic [3*CW-1:0]           up_pix,
  input  logic                      up_last,
  input  logic                      lo_valid,
  output logic                      lo_ready,
  input  logic [2:0]                lo_pix,
  output logic [3*CW-1:0]           lcd_data,
  output logic                      lcd_strobe
);
  localparam int unsigned BUS_W   = 3 * CW;
  localparam int unsigned HALF    = CW / 2;
  localparam int unsigned DEPTH_W = $clog2(CW + 1);

  logic rst_n_s;
  logic is_stn, is_dual, is_tft, mode_ok, wide;
  logic take, emit, flush_q, flush_d, strobe_q;
  logic [2:0] up_bits;
  logic up_emit, up_need_flush, lo_emit, lo_need_flush;
  logic [CW-1:0] up_word, lo_word;
  logic [BUS_W-1:0] tft_bus, bus_d, data_q, data_d;

  lcdf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  always_comb begin
    is_stn  = (mode == MODE_STN4) || (mode == MODE_STN8) ||
              (mode == MODE_DUAL8) || (mode == MODE_DUAL16);
    is_dual = (mode == MODE_DUAL8) || (mode == MODE_DUAL16);
    is_tft  = (mode == MODE_TFT);
    mode_ok = is_stn || is_tft;
    wide    = (mode == MODE_STN8) || (mode == MODE_DUAL16);
    up_bits = color ? {up_pix[3*CW-1], up_pix[2*CW-1], up_pix[CW-1]}
                    : {2'b00, up_pix[0]};
    up_ready = mode_ok && !flush_q && (!is_dual || lo_valid);
    lo_ready = is_dual && !flush_q && up_valid;
    take     = up_valid && up_ready;
  end

  lcdf_lane_packer #(.LANE_MAX(CW)) u_up_pack (
    .clk(clk), .rst_n(rst_n_s),
    .push(take && is_stn), .flush(flush_q), .last(up_last),
    .rgb(color), .wide(wide), .bits(up_bits),
    .emit(up_emit), .need_flush(up_need_flush), .word(up_word)
  );

  lcdf_lane_packer #(.LANE_MAX(CW)) u_lo_pack (
    .clk(clk), .rst_n(rst_n_s),
    .push(take && is_dual), .flush(flush_q && is_dual), .last(up_last),
    .rgb(color), .wide(wide), .bits(lo_pix),
    .emit(lo_emit), .need_flush(lo_need_flush), .word(lo_word)
  );

  lcdf_tft_map #(.COMP_W(CW), .DEPTH_W(DEPTH_W)) u_tft (
    .pix(up_pix), .depth(tft_depth), .bus(tft_bus)
  );

  always_comb begin
    bus_d = '0;
    case (mode)
      MODE_STN4:   bus_d[HALF-1:0] = up_word[HALF-1:0];
      MODE_STN8:   bus_d[CW-1:0]   = up_word;
      MODE_DUAL8:  bus_d[CW-1:0]   = {lo_word[HALF-1:0], up_word[HALF-1:0]};
      MODE_DUAL16: bus_d[2*CW-1:0] = {lo_word, up_word};
      MODE_TFT:    bus_d           = tft_bus;
      default:     bus_d           = '0;
    endcase
    emit    = is_tft ? take : up_emit;
    flush_d = take && is_stn && up_need_flush;
    data_d  = emit ? bus_d : data_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      data_q   <= '0;
      strobe_q <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      data_q   <= data_d;
      strobe_q <= emit;
      flush_q  <= flush_d;
    end
  end

  assign lcd_data   = data_q;
  assign lcd_strobe = strobe_q;

  // R8: dual-scan acceptance needs both halves present
  p_dual_both_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (take && is_dual) |-> (lo_valid && lo_ready));

  // R8: both half packers agree on word boundaries
  p_dual_lockstep_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (take && is_dual) |-> ((up_emit == lo_emit) && (up_need_flush == lo_need_flush)));

  // R10: reserved modes accept nothing
  p_reserved_idle_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mode_ok |-> (!up_ready && !lo_ready));

  // R10: lower stream is never accepted outside dual scan
  p_single_lo_idle_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !is_dual |-> !lo_ready);

  // R7: the padded follow-up word takes exactly one stalled cycle
  p_flush_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush_q |=> !flush_q);

  p_flush_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    flush_q |-> !up_ready);

  // R11: a TFT pixel produces a strobe on the next cycle
  p_tft_latency_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (take && is_tft) |=> lcd_strobe);

  // R2: STN words never touch the top colour byte
  p_stn_high_zero_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lcd_strobe && $past(is_stn)) |-> (lcd_data[BUS_W-1:2*CW] == '0));
endmodule

// File: tb/lcd_bus_formatter_tb.sv
module lcd_bus_formatter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic        color;
  logic [3:0]  tft_depth;
  logic        up_valid, up_ready, up_last;
  logic [23:0] up_pix;
  logic        lo_valid, lo_ready;
  logic [2:0]  lo_pix;
  logic [23:0] lcd_data;
  logic        lcd_strobe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [23:0] exp_q [0:63];
  int          exp_n  = 0;
  int          rd_idx = 0;
  string       cur_req = "R1";
  logic [7:0]  hw [0:1][0:47];

  always #10 clk = ~clk;

  lcd_bus_formatter u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .color(color), .tft_depth(tft_depth),
    .up_valid(up_valid), .up_ready(up_ready), .up_pix(up_pix), .up_last(up_last),
    .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_pix(lo_pix),
    .lcd_data(lcd_data), .lcd_strobe(lcd_strobe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [23:0] pix_of(input int i, input int seed);
    logic [31:0] x;
    x = (i + 1) * 32'h9E3779B1 ^ (seed * 32'h85EBCA6B);
    return x[31:8] ^ x[23:0];
  endfunction

  function automatic logic [2:0] lo_of(input int i, input int seed);
    logic [31:0] x;
    x = (i + 3) * 32'hC2B2AE35 ^ (seed * 32'h27D4EB2F);
    return x[14:12];
  endfunction

  // bit-serial model of one half: earliest bit on the highest lane line
  task automatic build_half(input int h, input int n, input bit rgb, input int w,
                            input int seed, output int nw);
    int j;
    logic [23:0] p;
    logic [2:0] b3;
    logic [2:0] seq;
    int nb;
    for (int k = 0; k < 48; k++) hw[h][k] = '0;
    j = 0;
    for (int i = 0; i < n; i++) begin
      if (h == 0) begin
        p = pix_of(i, seed);
        b3 = {p[23], p[15], p[7]};
        seq = rgb ? b3 : {2'b00, p[0]};
      end else begin
        b3 = lo_of(i, seed);
        seq = rgb ? b3 : {2'b00, b3[0]};
      end
      nb = rgb ? 3 : 1;
      for (int q = nb - 1; q >= 0; q--) begin
        hw[h][j / w][w - 1 - (j % w)] = seq[q];
        j++;
      end
    end
    nw = (j + w - 1) / w;
  endtask

  always @(negedge clk) begin
    if (rst_n && lcd_strobe) begin
      if (rd_idx < exp_n) begin
        chk(lcd_data == exp_q[rd_idx], cur_req, {8'h0, lcd_data}, {8'h0, exp_q[rd_idx]});
        rd_idx++;
      end else begin
        chk(1'b0, {cur_req, " unexpected strobe"}, {8'h0, lcd_data}, 32'h0);
      end
    end
  end

  task automatic run_line(input logic [2:0] m, input bit rgb, input int n,
                          input int seed, input logic [3:0] depth);
    bit dual;
    int w, nw0, nw1, i, cyc, d;
    bit prev_acc;
    logic [7:0] mk;
    logic [23:0] p;
    dual = (m == 3'd2) || (m == 3'd3);
    w = (m == 3'd1 || m == 3'd3) ? 8 : 4;
    @(negedge clk);
    mode = m; color = rgb; tft_depth = depth; up_valid = 0; lo_valid = 0;
    exp_n = 0; rd_idx = 0;
    if (m == 3'd4) begin
      d = (depth == 0 || depth > 8) ? 8 : int'(depth);
      mk = ~(8'hFF >> d);
      for (int k = 0; k < n; k++) begin
        p = pix_of(k, seed);
        exp_q[k] = {p[7:0] & mk, p[15:8] & mk, p[23:16] & mk};
      end
      exp_n = n;
      cur_req = "R9";
    end else begin
      build_half(0, n, rgb, w, seed, nw0);
      nw1 = nw0;
      if (dual) build_half(1, n, rgb, w, seed, nw1);
      for (int k = 0; k < nw0; k++) begin
        case (m)
          3'd0: exp_q[k] = {20'h0, hw[0][k][3:0]};
          3'd1: exp_q[k] = {16'h0, hw[0][k]};
          3'd2: exp_q[k] = {16'h0, hw[1][k][3:0], hw[0][k][3:0]};
          default: exp_q[k] = {8'h0, hw[1][k], hw[0][k]};
        endcase
      end
      exp_n = nw0;
      if (rgb) cur_req = "R6";
      else case (m)
        3'd0: cur_req = "R2";
        3'd1: cur_req = "R3";
        3'd2: cur_req = "R4";
        default: cur_req = "R5";
      endcase
    end
    i = 0; cyc = 0; prev_acc = 0;
    while (i < n) begin
      @(negedge clk);
      if (m == 3'd4 && prev_acc) chk(lcd_strobe == 1'b1, "R11 latency", {31'h0, lcd_strobe}, 32'h1);
      cyc++;
      up_valid = ((cyc * 7 + seed) % 5) != 0;
      lo_valid = dual ? (((cyc + seed) % 3) != 0) : cyc[0];
      up_pix   = pix_of(i, seed);
      lo_pix   = dual ? lo_of(i, seed) : ~up_pix[2:0];
      up_last  = (i == n - 1);
      #1;
      if (!dual) chk(lo_ready == 1'b0, "R10 lo_ready", {31'h0, lo_ready}, 32'h0);
      if (dual && up_valid && !lo_valid) chk(up_ready == 1'b0, "R8 one-sided", {31'h0, up_ready}, 32'h0);
      prev_acc = up_valid && up_ready;
      if (prev_acc) i++;
    end
    @(negedge clk);
    if (m == 3'd4 && prev_acc) chk(lcd_strobe == 1'b1, "R11 latency", {31'h0, lcd_strobe}, 32'h1);
    up_valid = 0; lo_valid = 0; up_last = 0;
    repeat (4) @(negedge clk);
    chk(rd_idx == exp_n, "R7 R11 word count", rd_idx, exp_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int lens [0:9] = '{1, 2, 3, 4, 5, 6, 7, 8, 11, 16};
    rst_n = 0; mode = 3'd0; color = 0; tft_depth = 4'd8;
    up_valid = 0; up_pix = '0; up_last = 0; lo_valid = 0; lo_pix = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(lcd_data == 24'h0, "R1 data", {8'h0, lcd_data}, 32'h0);
    chk(lcd_strobe == 1'b0, "R1 strobe", {31'h0, lcd_strobe}, 32'h0);

    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 2; c++)
        for (int li = 0; li < 10; li++)
          run_line(3'(m), c[0], lens[li], m * 31 + c * 7 + li, 4'd8);

    for (int d = 0; d < 10; d++)
      run_line(3'd4, 1'b0, 5, 100 + d, 4'(d));

    cur_req = "R10";
    exp_n = 0; rd_idx = 0;
    for (int m = 5; m < 8; m++) begin
      @(negedge clk);
      mode = 3'(m); up_valid = 1; lo_valid = 1; up_pix = pix_of(m, 9); up_last = 1;
      repeat (4) begin
        @(negedge clk);
        #1;
        chk(!up_ready && !lo_ready, "R10 reserved", {30'h0, up_ready, lo_ready}, 32'h0);
      end
      up_valid = 0; lo_valid = 0; up_last = 0;
      repeat (3) @(negedge clk);
      chk(rd_idx == 0, "R10 no strobe", rd_idx, 32'h0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule